// File: doc/BRIEF.md
# External Data Memory Address Router

This block sits between a small 8-bit microcontroller core and two data memories: a 4 KB on-chip RAM and an off-chip memory bus. Each external-data access from the core is either a short access, whose 16-bit address is built from an 8-bit page register (high byte) and an 8-bit indirect register (low byte), or a long access, whose address is a full 16-bit data pointer. The router forms that effective address, picks a destination from a 2-bit map-mode input, and issues a one-cycle enable to exactly one side.

There are four map modes. Code 00 keeps every access on-chip, with the address folded modulo 4 KB. Codes 01 and 10 split the space: addresses below 0x1000 go on-chip and the rest go off-chip. Code 11 sends everything off-chip. The two split modes differ only for short off-chip accesses. With code 10 the page register drives the upper address byte. With code 01 the upper byte is not driven and its drive enable stays low, so other logic can own those pins. Strobes, addresses, write data and the mode are captured on the clock edge where a strobe is seen. The outputs appear in the following cycle. Read data is returned from whichever side holds the enable in that cycle.

Top module: `xdata_router`

## Requirements
- R1: With map mode 00, every access enables only the on-chip side, and the on-chip address is the effective address modulo 4096 (for example, 0x1000 and 0x2000 both reach 0x000).
- R2: A short access (wideAccess=0) uses the effective address {pageReg, indLow}.
- R3: A long access (wideAccess=1) uses dataPtr as the effective address.
- R4: With map mode 01 or 10, an effective address below 0x1000 goes on-chip, and an address at or above 0x1000 goes off-chip.
- R5: With map mode 01, a short off-chip access drives offAddr[7:0] from indLow. It holds offDriveHi at 0 and offAddr[15:8] at 0, with offDriveLo at 1.
- R6: With map mode 01, a long off-chip access drives all 16 bits of offAddr from dataPtr, with both drive enables at 1.
- R7: With map mode 10, a short off-chip access drives offAddr = {pageReg, indLow}, with both drive enables at 1.
- R8: With map mode 11, every access goes off-chip with the full 16-bit address driven, and onEn stays 0.
- R9: A strobe seen on a clock edge produces, in the next cycle only, exactly one of onEn and offEn. The access is a write when wrStrobe is 1 (write wins if both strobes are 1) and a read otherwise. With no strobe, both enables are 0, including right after reset.
- R10: During a read's enable cycle, rdData equals onRdData when on-chip is selected and offRdData when off-chip is selected.
- R11: The map mode, the addresses and the write data are taken on the strobe edge. Changing the inputs afterwards does not alter the access already issued, and memWrData carries the captured write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapMode | input | 2 | Memory map selection (00 on-chip, 01 split with undriven page, 10 split with page, 11 off-chip) |
| wideAccess | input | 1 | 1 = address from data pointer, 0 = page plus indirect byte |
| pageReg | input | 8 | High address byte for short accesses |
| indLow | input | 8 | Low address byte for short accesses |
| dataPtr | input | 16 | Address for long accesses |
| rdStrobe | input | 1 | Read request |
| wrStrobe | input | 1 | Write request |
| wrData | input | 8 | Write data |
| onRdData | input | 8 | Read data from on-chip RAM |
| offRdData | input | 8 | Read data from off-chip bus |
| onEn | output | 1 | On-chip RAM access enable |
| onWe | output | 1 | On-chip RAM write enable |
| onAddr | output | 12 | On-chip RAM address |
| offEn | output | 1 | Off-chip access enable |
| offRd | output | 1 | Off-chip read strobe |
| offWr | output | 1 | Off-chip write strobe |
| offAddr | output | 16 | Off-chip address bus |
| offDriveLo | output | 1 | Drive enable for offAddr[7:0] |
| offDriveHi | output | 1 | Drive enable for offAddr[15:8] |
| memWrData | output | 8 | Captured write data to either memory |
| rdData | output | 8 | Read data returned to the core |

## Verification
The bench runs short and long accesses in every map mode. Its addresses sit on both sides of the 0x1000 boundary (0x0FFF, 0x1000, 0x0800, page 0x0F versus page 0x12), which separates a wrong threshold from a wrong destination. It also uses addresses above 4 KB in mode 00 to show the modulo fold. Short off-chip accesses in modes 01 and 10 use the same page and indirect values, so only the upper-byte drive separates the two split modes. On every access, the bench inverts the mode and all address inputs in the cycle after the strobe, so any result that tracks live inputs instead of captured ones shows up. Reads, writes and a simultaneous read-and-write check the strobe priority. Distinct on-chip and off-chip read values show which side fed rdData.

// File: rtl/xroute_pkg.sv
package xroute_pkg;
  typedef enum logic [1:0] {
    MAP_ON         = 2'b00,
    MAP_SPLIT_FLAT = 2'b01,
    MAP_SPLIT_BANK = 2'b10,
    MAP_OFF        = 2'b11
  } mapMode_t;

  typedef struct packed {
    logic onSel;
    logic offSel;
    logic write;
    logic driveHi;
  } strobes_t;
endpackage

// File: rtl/xroute_ctrl.sv
module xroute_ctrl
  import xroute_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  mapMode_t mode,
  input  logic     wide,
  input  logic     rdStrobe,
  input  logic     wrStrobe,
  input  logic     aboveOnChip,
  output strobes_t strb
);
  logic acc;
  logic goOff;
  logic hiAllowed;

  assign acc = rdStrobe | wrStrobe;

  always_comb begin
    case (mode)
      MAP_ON:  goOff = 1'b0;
      MAP_OFF: goOff = 1'b1;
      default: goOff = aboveOnChip;
    endcase
  end

  // the page byte is withheld only for short accesses in the flat split map
  assign hiAllowed = !(mode == MAP_SPLIT_FLAT && !wide);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strb <= '0;
    end else begin
      strb.onSel   <= acc && !goOff;
      strb.offSel  <= acc && goOff;
      strb.write   <= wrStrobe;
      strb.driveHi <= acc && goOff && hiAllowed;
    end
  end

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.onSel && strb.offSel)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !acc |=> !strb.onSel && !strb.offSel); // R9
  AST_MAP_ON_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    (acc && mode == MAP_ON) |=> strb.onSel && !strb.driveHi); // R1
  AST_MAP_OFF_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (acc && mode == MAP_OFF) |=> strb.offSel && strb.driveHi); // R8
  AST_FLAT_SHORT_NOHI: assert property (@(posedge clk) disable iff (!rstN)
    (acc && mode == MAP_SPLIT_FLAT && !wide) |=> !strb.driveHi); // R5
endmodule

// File: rtl/xroute_dp.sv
module xroute_dp
  import xroute_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ON_AW  = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 acc,
  input  logic                 wide,
  input  logic [ADDR_W-DATA_W-1:0] pageReg,
  input  logic [DATA_W-1:0]    indLow,
  input  logic [ADDR_W-1:0]    dataPtr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    onRdData,
  input  logic [DATA_W-1:0]    offRdData,
  input  strobes_t             strb,
  output logic                 aboveOnChip,
  output logic                 onEn,
  output logic                 onWe,
  output logic [ON_AW-1:0]     onAddr,
  output logic                 offEn,
  output logic                 offRd,
  output logic                 offWr,
  output logic [ADDR_W-1:0]    offAddr,
  output logic                 offDriveLo,
  output logic                 offDriveHi,
  output logic [DATA_W-1:0]    memWrData,
  output logic [DATA_W-1:0]    rdData
);
  localparam int LOW_W = DATA_W;
  localparam int HI_W  = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  assign effAddr     = wide ? dataPtr : {pageReg, indLow};
  assign aboveOnChip = |effAddr[ADDR_W-1:ON_AW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (acc) begin
      addrQ <= effAddr;
      dataQ <= wrData;
    end
  end

  assign onEn       = strb.onSel;
  assign onWe       = strb.onSel && strb.write;
  assign onAddr     = addrQ[ON_AW-1:0];
  assign offEn      = strb.offSel;
  assign offRd      = strb.offSel && !strb.write;
  assign offWr      = strb.offSel && strb.write;
  assign offDriveLo = strb.offSel;
  assign offDriveHi = strb.driveHi;
  assign offAddr    = {(strb.driveHi ? addrQ[ADDR_W-1:LOW_W] : {HI_W{1'b0}}),
                       addrQ[LOW_W-1:0]};
  assign memWrData  = dataQ;
  assign rdData     = strb.offSel ? offRdData : onRdData;

  AST_HI_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (offEn && !offDriveHi) |-> offAddr[ADDR_W-1:LOW_W] == '0); // R5
  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rstN)
    offDriveHi |-> offDriveLo); // R6
endmodule

// File: rtl/xdata_router.sv
module xdata_router
  import xroute_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ON_AW  = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               mapMode,
  input  logic                     wideAccess,
  input  logic [ADDR_W-DATA_W-1:0] pageReg,
  input  logic [DATA_W-1:0]        indLow,
  input  logic [ADDR_W-1:0]        dataPtr,
  input  logic                     rdStrobe,
  input  logic                     wrStrobe,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W-1:0]        onRdData,
  input  logic [DATA_W-1:0]        offRdData,
  output logic                     onEn,
  output logic                     onWe,
  output logic [ON_AW-1:0]         onAddr,
  output logic                     offEn,
  output logic                     offRd,
  output logic                     offWr,
  output logic [ADDR_W-1:0]        offAddr,
  output logic                     offDriveLo,
  output logic                     offDriveHi,
  output logic [DATA_W-1:0]        memWrData,
  output logic [DATA_W-1:0]        rdData
);
  strobes_t strb;
  logic     aboveOnChip;

  xroute_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mapMode_t'(mapMode)), .wide(wideAccess),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .aboveOnChip(aboveOnChip),
    .strb(strb)
  );

  xroute_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ON_AW(ON_AW)) dp_i (
    .clk(clk), .rstN(rstN), .acc(rdStrobe | wrStrobe), .wide(wideAccess),
    .pageReg(pageReg), .indLow(indLow), .dataPtr(dataPtr), .wrData(wrData),
    .onRdData(onRdData), .offRdData(offRdData), .strb(strb),
    .aboveOnChip(aboveOnChip), .onEn(onEn), .onWe(onWe), .onAddr(onAddr),
    .offEn(offEn), .offRd(offRd), .offWr(offWr), .offAddr(offAddr),
    .offDriveLo(offDriveLo), .offDriveHi(offDriveHi),
    .memWrData(memWrData), .rdData(rdData)
  );
endmodule

// File: tb/xdata_router_tb_top.sv
module xdata_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mapMode = 2'b00;
  logic        wideAccess = 1'b0;
  logic [7:0]  pageReg = '0, indLow = '0, wrData = '0;
  logic [15:0] dataPtr = '0;
  logic        rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [7:0]  onRdData = 8'hA5, offRdData = 8'h3C;
  logic        onEn, onWe, offEn, offRd, offWr, offDriveLo, offDriveHi;
  logic [11:0] onAddr;
  logic [15:0] offAddr;
  logic [7:0]  memWrData, rdData;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xdata_router dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic [1:0] md, input bit w,
                        input logic [7:0] pg, input logic [7:0] ind,
                        input logic [15:0] dp, input bit rd, input bit wr,
                        input logic [7:0] wd);
    logic [15:0] eff;
    bit goOff, hi;
    eff   = w ? dp : {pg, ind};
    goOff = (md == 2'b11) || ((md == 2'b01 || md == 2'b10) && eff >= 16'h1000);
    hi    = goOff && !(md == 2'b01 && !w);
    @(negedge clk);
    mapMode = md; wideAccess = w; pageReg = pg; indLow = ind; dataPtr = dp;
    rdStrobe = rd; wrStrobe = wr; wrData = wd;
    @(negedge clk);
    // R11: scramble live inputs while the issued access is on the outputs
    mapMode = ~md; pageReg = ~pg; indLow = ~ind; dataPtr = ~dp; wrData = ~wd;
    rdStrobe = 1'b0; wrStrobe = 1'b0;
    #1;
    chk({tag, " R9 one side"}, onEn + offEn, 1);
    chk({tag, " onEn"}, onEn, !goOff);
    chk({tag, " offDriveLo"}, offDriveLo, goOff);
    chk({tag, " offDriveHi"}, offDriveHi, hi);
    if (!goOff) begin
      chk({tag, " onAddr"}, onAddr, eff[11:0]);
      chk({tag, " R9 onWe"}, onWe, wr);
    end else begin
      chk({tag, " offAddr"}, offAddr, {(hi ? eff[15:8] : 8'h00), eff[7:0]});
      chk({tag, " R9 offWr"}, offWr, wr);
      chk({tag, " R9 offRd"}, offRd, !wr);
    end
    if (wr) chk({tag, " R11 memWrData"}, memWrData, wd);
    else    chk({tag, " R10 rdData"}, rdData, goOff ? 8'h3C : 8'hA5);
    @(negedge clk);
    #1;
    chk({tag, " R9 pulse ends"}, onEn | offEn, 0);
  endtask

  task automatic tReset();
    chk("R9 reset onEn", onEn, 0);
    chk("R9 reset offEn", offEn, 0);
  endtask

  task automatic tMapOn();
    access("R1 wrap 0x1000", 2'b00, 1, 8'h00, 8'h00, 16'h1000, 1, 0, 8'h00);
    access("R1 wrap 0x2000", 2'b00, 1, 8'h00, 8'h00, 16'h2000, 0, 1, 8'h5A);
    access("R2 short page", 2'b00, 0, 8'h3A, 8'h55, 16'hFFFF, 1, 0, 8'h00);
  endtask

  task automatic tSplitFlat();
    access("R4 R3 long below", 2'b01, 1, 8'hFF, 8'hFF, 16'h0FFF, 1, 0, 8'h00);
    access("R6 R3 long at 0x1000", 2'b01, 1, 8'h00, 8'h00, 16'h1000, 0, 1, 8'h77);
    access("R5 short off", 2'b01, 0, 8'h12, 8'h34, 16'h0000, 0, 1, 8'h91);
    access("R4 short below", 2'b01, 0, 8'h0F, 8'hEE, 16'hFFFF, 1, 0, 8'h00);
  endtask

  task automatic tSplitBank();
    access("R7 short off", 2'b10, 0, 8'h12, 8'h34, 16'h0000, 1, 0, 8'h00);
    access("R7 page 0x80", 2'b10, 0, 8'h80, 8'h01, 16'h0000, 0, 1, 8'h42);
    access("R4 long below", 2'b10, 1, 8'hFF, 8'hFF, 16'h0800, 0, 1, 8'h24);
  endtask

  task automatic tMapOff();
    access("R8 low address", 2'b11, 1, 8'h00, 8'h00, 16'h0005, 1, 0, 8'h00);
    access("R8 short", 2'b11, 0, 8'h00, 8'h10, 16'hFFFF, 0, 1, 8'hC3);
  endtask

  task automatic tPriority();
    access("R9 both strobes", 2'b00, 1, 8'h00, 8'h00, 16'h0123, 1, 1, 8'hE1);
    access("R9 both strobes off", 2'b11, 1, 8'h00, 8'h00, 16'hBEEF, 1, 1, 8'h1E);
  endtask

  task automatic tModeSwitch();
    access("R11 on then off", 2'b00, 1, 8'h00, 8'h00, 16'h4321, 1, 0, 8'h00);
    access("R11 off then on", 2'b11, 1, 8'h00, 8'h00, 16'h0042, 0, 1, 8'h66);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    tReset();
    rstN = 1'b1;
    tMapOn();
    tSplitFlat();
    tSplitBank();
    tMapOff();
    tPriority();
    tModeSwitch();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule